// File: doc/BRIEF.md
# Up/Down Timer with Update-Rate Divider

The block is a triangle-wave timer. Once started, its counter climbs from zero to a programmed top value and falls back to zero, repeating without pause. Each turnaround is a repetition event: the peak (overflow) and the valley (underflow) both count. An internal repetition down-counter thins these events out, so the update-event output fires once every (R+1) turnarounds.

Software reaches the block through one write port with four addresses. The top value is written directly. The repetition value R goes into a preload register and is copied into the internal counter only when an update event occurs. A software update request raises an update at once, reloads the repetition counter and restarts the main counter from zero.

Whether updates land on peaks or on valleys depends on when R was loaded relative to the start. A value written before start behaves differently from one written while the counter runs.

Top module: `updown_rep_timer`

## Requirements
- R1: After reset, the counter is 0, the direction output is 0 (up), the overflow, underflow and update outputs are low, and the top value, the repetition preload, the internal repetition count and the run flag are all 0.
- R2: While running with a top value T greater than 0, the counter follows 0, 1, …, T, T-1, …, 1, 0, 1, … with no value repeated at either end. The direction output is 1 (down) from the cycle after the counter shows T through the cycle in which it shows 0 again, and 0 (up) otherwise.
- R3: The overflow output pulses in the cycle the counter shows T while counting up. The underflow output pulses in the cycle the counter shows 0 while counting down. Each pulse is one repetition event.
- R4: On a repetition event, if the internal repetition count is 0 the update output is high in that same cycle and the count is reloaded from the preload; otherwise the count is decremented. This gives one update per R+1 events, and an update on every event while R is 0.
- R5: Address 1 (low 8 bits of the write data) writes the repetition preload. The internal count ignores the new value until the next update event.
- R6: If R = 1 is written before the counter is started, with no software update request, every update lands on an overflow and none lands on an underflow.
- R7: With a repetition count of 1 already loaded, writing R = 2 after the start gives the first update at the first underflow (event 2). After that the updates fall on events 5 and 8.
- R8: A write to address 3 raises the update output in the same cycle as the write. In the next cycle the counter is 0, the direction is up, and the internal count holds the preload.
- R9: Address 0 writes the 16-bit top value. While the top value is 0, the counter holds its value and no overflow, underflow or repetition-driven update occurs.
- R10: Address 2 bit 0 is the run flag. While it is 0, the counter holds its value and no events occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 top value, 1 repetition preload, 2 run flag, 3 software update |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Live counter value |
| dir_o | output | 1 | 0 counting up, 1 counting down |
| ovf_o | output | 1 | Overflow (peak) event pulse |
| unf_o | output | 1 | Underflow (valley) event pulse |
| upd_o | output | 1 | Update event pulse |

## Verification
The bench compares the counter against the ideal triangle, cycle by cycle. A design that repeats the top or zero value, or turns around a cycle late, shows a wrong count within one period. It loads an odd R before start and checks that updates stay on the peaks; a design that seeds the repetition counter at start moves them onto the valleys. It rewrites R while running and checks the event indices of the first updates; a design that applies the preload at once, and not at the next update, shifts them. The bench also covers a zero top value, a stopped counter, a top value of one (an event on every cycle) and the software update request. A design that ignores the request, or delays its pulse by one cycle, fails those checks.

// File: rtl/updown_rep_timer.sv
module updown_rep_timer #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] top_q, cnt_q;
  logic [REP_W-1:0] pre_q, rep_q;
  logic             run_q, down_q;

  wire sw_ug = wr_en && (wr_addr == 2'd3);
  wire step  = run_q && (top_q != '0);
  wire ovf   = step && !down_q && (cnt_q >= top_q);
  wire unf   = step && down_q && (cnt_q == '0);
  wire event_hit = ovf || unf;

  assign cnt_o = cnt_q;
  assign dir_o = down_q;
  assign ovf_o = ovf;
  assign unf_o = unf;
  assign upd_o = sw_ug || (event_hit && (rep_q == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q  <= '0;
      pre_q  <= '0;
      rep_q  <= '0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0:    top_q <= wr_data;
          2'd1:    pre_q <= wr_data[REP_W-1:0];
          2'd2:    run_q <= wr_data[0];
          default: ;
        endcase
      end
      if (sw_ug) begin
        cnt_q  <= '0;
        down_q <= 1'b0;
        rep_q  <= pre_q;
      end else if (step) begin
        if (ovf) begin
          cnt_q  <= cnt_q - ONE;
          down_q <= 1'b1;
        end else if (unf) begin
          cnt_q  <= ONE;
          down_q <= 1'b0;
        end else begin
          cnt_q <= down_q ? cnt_q - ONE : cnt_q + ONE;
        end
        if (event_hit)
          rep_q <= (rep_q == '0) ? pre_q : rep_q - REP_W'(1);
      end
    end
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !event_hit && !sw_ug) |=>
      (cnt_q == ($past(down_q) ? $past(cnt_q) - ONE : $past(cnt_q) + ONE)));

  // R3
  peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !sw_ug) |=> (down_q && !ovf));

  // R3
  valley_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !sw_ug) |=> (!down_q && cnt_q == ONE));

  // R4
  upd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (event_hit || sw_ug));

  // R8
  sw_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ug |=> (cnt_q == '0 && !down_q && rep_q == $past(pre_q)));

  // R9
  zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q == '0 && !sw_ug) |=> $stable(cnt_q));

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !sw_ug) |=> $stable(cnt_q));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q == '0 || !run_q) |-> !(ovf_o || unf_o));
endmodule

// File: tb/test_updown_rep_timer.sv
module test_updown_rep_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic        dir_o, ovf_o, unf_o, upd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updown_rep_timer i_updown_rep_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .dir_o(dir_o), .ovf_o(ovf_o), .unf_o(unf_o), .upd_o(upd_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "cnt", cnt_o, 0);
    chk("R1", "dir", dir_o, 0);
    chk("R1", "pulses", {ovf_o, unf_o, upd_o}, 0);
  endtask

  task automatic t_triangle();
    int bad = 0;
    do_reset();
    wr(2'd0, 16'd3);
    wr(2'd2, 16'd1);
    for (int k = 0; k < 14; k++) begin
      int m = k % 6;
      int ec = (m <= 3) ? m : 6 - m;
      int ed = ((m > 3) || (m == 0 && k > 0)) ? 1 : 0;
      int eo = (m == 3) ? 1 : 0;
      int eu = (m == 0 && k > 0) ? 1 : 0;
      chk("R2", "cnt", cnt_o, ec);
      chk("R2", "dir", dir_o, ed);
      chk("R3", "ovf", ovf_o, eo);
      chk("R3", "unf", unf_o, eu);
      chk("R4", "upd with R=0", upd_o, eo | eu);
      @(negedge clk);
    end
  endtask

  task automatic t_zero_top();
    int ev = 0;
    do_reset();
    wr(2'd2, 16'd1);
    for (int k = 0; k < 10; k++) begin
      if (cnt_o != 0) ev++;
      if (ovf_o || unf_o || upd_o) ev++;
      @(negedge clk);
    end
    chk("R9", "activity with top 0", ev, 0);
  endtask

  task automatic t_odd_before_start();
    int on_ovf = 0, on_unf = 0;
    do_reset();
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd1);
    for (int k = 0; k < 24; k++) begin
      if (upd_o && ovf_o) on_ovf++;
      if (upd_o && unf_o) on_unf++;
      @(negedge clk);
    end
    chk("R6", "updates on overflow", on_ovf, 6);
    chk("R6", "updates on underflow", on_unf, 0);
  endtask

  task automatic t_after_start();
    int e = 0, u = 0;
    int idx[3];
    int kind[3];
    do_reset();
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd1);
    wr(2'd3, 16'd0);
    wr(2'd2, 16'd1);
    wr(2'd1, 16'd2);
    for (int k = 0; k < 22; k++) begin
      if (ovf_o || unf_o) begin
        e++;
        if (upd_o && u < 3) begin
          idx[u] = e;
          kind[u] = unf_o;
          u++;
        end
      end
      @(negedge clk);
    end
    chk("R7", "update count", u, 3);
    chk("R7", "first update event", idx[0], 2);
    chk("R7", "first update on underflow", kind[0], 1);
    chk("R5", "second update event", idx[1], 5);
    chk("R5", "third update event", idx[2], 8);
  endtask

  task automatic t_sw_update();
    int e = 0, first = 0, first_ovf = 0;
    do_reset();
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd1);
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = '0;
    #1;
    chk("R8", "upd during write", upd_o, 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8", "cnt after request", cnt_o, 0);
    chk("R8", "dir after request", dir_o, 0);
    for (int k = 0; k < 20; k++) begin
      if (ovf_o || unf_o) begin
        e++;
        if (upd_o && first == 0) begin
          first = e;
          first_ovf = ovf_o;
        end
      end
      @(negedge clk);
    end
    chk("R8", "first update event after reload", first, 3);
    chk("R8", "first update on overflow", first_ovf, 1);
  endtask

  task automatic t_stop();
    int ev = 0;
    logic [15:0] held;
    do_reset();
    wr(2'd0, 16'd5);
    wr(2'd2, 16'd1);
    repeat (3) @(negedge clk);
    wr(2'd2, 16'd0);
    held = cnt_o;
    for (int k = 0; k < 8; k++) begin
      if (cnt_o != held) ev++;
      if (ovf_o || unf_o || upd_o) ev++;
      @(negedge clk);
    end
    chk("R10", "held value", held, 4);
    chk("R10", "activity while stopped", ev, 0);
  endtask

  task automatic t_top_one();
    do_reset();
    wr(2'd0, 16'd1);
    wr(2'd2, 16'd1);
    @(negedge clk);
    for (int k = 1; k < 7; k++) begin
      chk("R3", "ovf top 1", ovf_o, k % 2);
      chk("R3", "unf top 1", unf_o, 1 - (k % 2));
      chk("R4", "upd top 1", upd_o, 1);
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_triangle();
    t_zero_top();
    t_odd_before_start();
    t_after_start();
    t_sw_update();
    t_stop();
    t_top_one();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule